// File: doc/BRIEF.md
# Strobed PCM Serial Port

This block is the digital serial side of a voice codec channel. Once per 8 kHz frame an external framer raises an active-high strobe for one 8-bit timeslot. Inside that slot one companded sample goes out on the serial data line and one comes in, both MSB first and both in the same slot. Outgoing bits change after rising bit-clock edges. Incoming bits are sampled on falling edges. The encoder and decoder sit outside the block and are seen only as parallel bytes: `enc_byte` is the outgoing sample, and `rx_byte` with its one-cycle `rx_valid` pulse is the incoming one.

The bit clock, strobe and serial input are brought into the system clock domain through a synchroniser and then edge-detected, so all logic runs on `clk`. A frame state machine has three states. `S_IDLE` waits for a strobe rise, which is transition *open*. `S_SLOT` counts falling bit-clock edges and leaves on the eighth one, transition *complete*, to `S_DRAIN`; if the strobe drops first it returns to `S_IDLE`, transition *abort*. `S_DRAIN` holds until the strobe drops, transition *close*. Each direction has its own mute. A mute replaces that direction's byte with the negative-zero quiet code of the selected companding law.

In synchronous mode a sample passes through within its own frame. In asynchronous mode both directions are double-buffered and the buffers swap at each strobe rise, which adds exactly one frame of delay.

Top module: `pcm_strobe_port`

## Requirements
- R1: While `rst_n` is low, `sdout_en`, `rx_valid` and `rx_byte` are 0. After release with the strobe low they stay 0, and pulling `rst_n` low inside an open slot turns the driver off.
- R2: A strobe rise in `S_IDLE` loads the transmit byte. Its bit 7 is on `sdout` before the first falling bit-clock edge, and each later bit appears after a rising edge that follows a falling edge in the slot.
- R3: `sdin` is sampled on falling bit-clock edges while the strobe is high. The first sampled bit becomes bit 7 of the received byte, and at most 8 bits are taken per slot.
- R4: `sdout_en` is 1 only while a slot is open (state not `S_IDLE`) and returns to 0 a few clocks after the strobe falls. While it is 0, `sdout` is 0.
- R5: With `tx_mute`=1 the transmitted byte is the quiet code. The quiet code is 0x7F when `law_a`=0 (mu-law) and 0x55 when `law_a`=1 (A-law).
- R6: With `rx_mute`=1 the byte delivered on `rx_byte` is the quiet code of the selected law (0x7F or 0x55).
- R7: With `async_mode`=0, `rx_byte` and `rx_valid` update a few clocks after the eighth falling edge of the same slot, and the bits sent are that slot's `enc_byte` (or the quiet code).
- R8: `rx_valid` is one clock wide, and there is exactly one pulse per delivered byte.
- R9: A slot with fewer than 8 falling edges delivers nothing: no pulse, `rx_byte` unchanged, and in asynchronous mode the partial byte is not delivered later.
- R10: With `async_mode`=1 the byte captured at a slot's strobe rise is sent in the next slot. The first slot after reset sends the quiet code.
- R11: With `async_mode`=1 a byte completed in one slot is delivered, with its `rx_valid` pulse, at the strobe rise of the next slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Active-low power-up reset, asynchronous |
| bclk | input | 1 | Serial bit clock |
| strobe | input | 1 | Active-high timeslot strobe, 8 kHz |
| sdin | input | 1 | Serial data in |
| async_mode | input | 1 | 1 selects the one-frame buffered mode |
| law_a | input | 1 | 1 selects A-law, 0 selects mu-law |
| tx_mute | input | 1 | Send quiet code instead of `enc_byte` |
| rx_mute | input | 1 | Deliver quiet code instead of received data |
| enc_byte | input | 8 | Byte from the encoder side |
| sdout | output | 1 | Serial data out |
| sdout_en | output | 1 | Output enable for the tri-state driver |
| rx_byte | output | 8 | Byte for the decoder side |
| rx_valid | output | 1 | One-cycle pulse when `rx_byte` is new |

## Verification
The assertions check on every cycle the invariants that tie the state machine to the ports. The driver is off in `S_IDLE`. The enable rises only on a load. A muted load produces the quiet code. `rx_valid` is a single-cycle pulse. The bit count stays bounded. A synchronous delivery happens only on entry to `S_DRAIN`. Whether the bits come out in the right order and with the right value, whether a short slot is really discarded, and whether asynchronous mode delays each direction by exactly one frame can only be seen across whole frames. The bench's vector table and its directed scenarios cover these.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;

    typedef enum logic [1:0] {
        S_IDLE  = 2'd0,
        S_SLOT  = 2'd1,
        S_DRAIN = 2'd2
    } slot_state_t;

    localparam int unsigned SAMPLE_W = 8;

    function automatic logic [SAMPLE_W-1:0] quiet_code(input logic law_a);
        return law_a ? 8'h55 : 8'h7F;
    endfunction

endpackage

// File: rtl/pcm_in_sync.sv
module pcm_in_sync #(
    parameter int N      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d,
    output logic [N-1:0] q
);
    logic [STAGES-1:0][N-1:0] stg;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg <= '0;
                else        stg[0] <= d;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg <= '0;
                else        stg <= {stg[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/pcm_slot_fsm.sv
module pcm_slot_fsm
    import pcm_port_pkg::*;
#(
    parameter int W     = 8,
    localparam int CNT_W = $clog2(W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stb,
    input  logic             bck,
    output slot_state_t      state,
    output logic             open_slot,
    output logic             close_slot,
    output logic             rx_shift,
    output logic             rx_done,
    output logic             tx_shift,
    output logic [CNT_W-1:0] bit_cnt
);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(W - 1);

    logic        stb_q, bck_q;
    logic        stb_rise, stb_fall, bck_rise, bck_fall;
    slot_state_t nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stb_q <= 1'b0;
            bck_q <= 1'b0;
        end else begin
            stb_q <= stb;
            bck_q <= bck;
        end
    end

    assign stb_rise = stb & ~stb_q;
    assign stb_fall = ~stb & stb_q;
    assign bck_rise = bck & ~bck_q;
    assign bck_fall = ~bck & bck_q;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= nxt;
    end

    // next state: open, complete, abort, close
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE:  if (stb_rise) nxt = S_SLOT;
            S_SLOT:  if (stb_fall) nxt = S_IDLE;
                     else if (bck_fall && bit_cnt == LAST) nxt = S_DRAIN;
            S_DRAIN: if (stb_fall) nxt = S_IDLE;
            default: nxt = S_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        open_slot  = (state == S_IDLE) && stb_rise;
        close_slot = stb_fall;
        rx_shift   = (state == S_SLOT) && stb && bck_fall;
        rx_done    = rx_shift && (bit_cnt == LAST);
        tx_shift   = (state != S_IDLE) && stb && bck_rise && (bit_cnt != '0);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        bit_cnt <= '0;
        else if (open_slot) bit_cnt <= '0;
        else if (rx_shift)  bit_cnt <= bit_cnt + 1'b1;
    end

    // R3
    bit_cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_cnt <= CNT_W'(W));
endmodule

// File: rtl/pcm_tx_path.sv
module pcm_tx_path
    import pcm_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic         shift,
    input  logic         close_slot,
    input  logic         async_mode,
    input  logic         law_a,
    input  logic         tx_mute,
    input  logic [W-1:0] enc_byte,
    output logic         sdout,
    output logic         sdout_en
);
    logic [W-1:0] sh, hold, pick, quiet;
    logic         hold_full;

    assign quiet = W'(quiet_code(law_a));
    assign pick  = tx_mute ? quiet : enc_byte;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh        <= '0;
            hold      <= '0;
            hold_full <= 1'b0;
            sdout_en  <= 1'b0;
        end else if (close_slot) begin
            sdout_en <= 1'b0;
        end else if (load) begin
            sdout_en <= 1'b1;
            if (async_mode) begin
                sh        <= hold_full ? hold : quiet;
                hold      <= pick;
                hold_full <= 1'b1;
            end else begin
                sh <= pick;
            end
        end else if (shift) begin
            sh <= {sh[W-2:0], 1'b0};
        end
    end

    assign sdout = sdout_en & sh[W-1];

    // R2
    en_from_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sdout_en) |-> $past(load));

    // R5
    mute_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && tx_mute && !async_mode && !close_slot) |=> (sh == W'(quiet_code(law_a))));
endmodule

// File: rtl/pcm_rx_path.sv
module pcm_rx_path
    import pcm_port_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift,
    input  logic         done,
    input  logic         present,
    input  logic         sdin,
    input  logic         async_mode,
    input  logic         law_a,
    input  logic         rx_mute,
    output logic [W-1:0] rx_byte,
    output logic         rx_valid
);
    logic [W-1:0] sh, pend, fin;
    logic         pend_full;

    assign fin = rx_mute ? W'(quiet_code(law_a)) : {sh[W-2:0], sdin};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh        <= '0;
            pend      <= '0;
            pend_full <= 1'b0;
            rx_byte   <= '0;
            rx_valid  <= 1'b0;
        end else begin
            rx_valid <= 1'b0;
            if (shift) sh <= {sh[W-2:0], sdin};
            if (done) begin
                if (async_mode) begin
                    pend      <= fin;
                    pend_full <= 1'b1;
                end else begin
                    rx_byte  <= fin;
                    rx_valid <= 1'b1;
                end
            end else if (present && async_mode && pend_full) begin
                rx_byte   <= pend;
                rx_valid  <= 1'b1;
                pend_full <= 1'b0;
            end
        end
    end

    // R8
    valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R11
    pend_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && async_mode) |=> pend_full);
endmodule

// File: rtl/pcm_strobe_port.sv
module pcm_strobe_port
    import pcm_port_pkg::*;
#(
    parameter int W           = 8,
    parameter int SYNC_STAGES = 2,
    localparam int CNT_W      = $clog2(W + 1)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bclk,
    input  logic         strobe,
    input  logic         sdin,
    input  logic         async_mode,
    input  logic         law_a,
    input  logic         tx_mute,
    input  logic         rx_mute,
    input  logic [W-1:0] enc_byte,
    output logic         sdout,
    output logic         sdout_en,
    output logic [W-1:0] rx_byte,
    output logic         rx_valid
);
    logic [2:0]       sync_q;
    slot_state_t      state;
    logic             open_slot, close_slot, rx_shift, rx_done, tx_shift;
    logic [CNT_W-1:0] bit_cnt;

    pcm_in_sync #(.N(3), .STAGES(SYNC_STAGES)) i_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({strobe, bclk, sdin}),
        .q     (sync_q)
    );

    pcm_slot_fsm #(.W(W)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .stb        (sync_q[2]),
        .bck        (sync_q[1]),
        .state      (state),
        .open_slot  (open_slot),
        .close_slot (close_slot),
        .rx_shift   (rx_shift),
        .rx_done    (rx_done),
        .tx_shift   (tx_shift),
        .bit_cnt    (bit_cnt)
    );

    pcm_tx_path #(.W(W)) i_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .load       (open_slot),
        .shift      (tx_shift),
        .close_slot (close_slot),
        .async_mode (async_mode),
        .law_a      (law_a),
        .tx_mute    (tx_mute),
        .enc_byte   (enc_byte),
        .sdout      (sdout),
        .sdout_en   (sdout_en)
    );

    pcm_rx_path #(.W(W)) i_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .shift      (rx_shift),
        .done       (rx_done),
        .present    (open_slot),
        .sdin       (sync_q[0]),
        .async_mode (async_mode),
        .law_a      (law_a),
        .rx_mute    (rx_mute),
        .rx_byte    (rx_byte),
        .rx_valid   (rx_valid)
    );

    // R4
    idle_driver_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_IDLE) |-> !sdout_en);

    // R7
    sync_deliver_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !async_mode) |-> (state == S_DRAIN));
endmodule

// File: tb/test_pcm_strobe_port.sv
`timescale 1ns/1ps
module test_pcm_strobe_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bclk = 1'b1, strobe = 1'b0, sdin = 1'b0;
    logic       async_mode = 1'b0, law_a = 1'b0, tx_mute = 1'b0, rx_mute = 1'b0;
    logic [7:0] enc_byte = 8'h00;
    logic       sdout, sdout_en, rx_valid;
    logic [7:0] rx_byte;

    int         n_chk = 0, n_bad = 0, vcnt = 0;
    logic [7:0] got_tx;
    logic       en_ok;
    bit         done_flag = 0;

    always #2.5 clk = ~clk;

    pcm_strobe_port i_pcm_strobe_port (
        .clk(clk), .rst_n(rst_n), .bclk(bclk), .strobe(strobe), .sdin(sdin),
        .async_mode(async_mode), .law_a(law_a), .tx_mute(tx_mute), .rx_mute(rx_mute),
        .enc_byte(enc_byte), .sdout(sdout), .sdout_en(sdout_en),
        .rx_byte(rx_byte), .rx_valid(rx_valid)
    );

    always @(negedge clk) if (rst_n && rx_valid) vcnt++;

    // {law_a, tx_mute, rx_mute, enc, din, expected tx, expected rx}
    localparam logic [34:0] VEC [7] = '{
        {1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C, 8'hA5, 8'h3C},
        {1'b1, 1'b0, 1'b0, 8'h81, 8'h7E, 8'h81, 8'h7E},
        {1'b0, 1'b1, 1'b0, 8'h12, 8'hC3, 8'h7F, 8'hC3},
        {1'b1, 1'b1, 1'b0, 8'h12, 8'hC3, 8'h55, 8'hC3},
        {1'b0, 1'b0, 1'b1, 8'hF0, 8'h0F, 8'hF0, 8'h7F},
        {1'b1, 1'b1, 1'b1, 8'h00, 8'hFF, 8'h55, 8'h55},
        {1'b0, 1'b0, 1'b0, 8'hFF, 8'h00, 8'hFF, 8'h00}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(input logic amode);
        rst_n = 1'b0;
        strobe = 1'b0; bclk = 1'b1; sdin = 1'b0;
        async_mode = amode;
        #50;
        rst_n = 1'b1;
        #50;
    endtask

    // one slot with nbits bit-clock periods; collects the serial output
    task automatic do_frame(input logic [7:0] din, input int nbits);
        got_tx = 8'h00;
        en_ok  = 1'b1;
        strobe = 1'b1;
        for (int i = 0; i < nbits; i++) begin
            sdin = din[7-i];
            #40;
            got_tx[7-i] = sdout;
            if (sdout_en !== 1'b1) en_ok = 1'b0;
            bclk = 1'b0;
            #40;
            bclk = 1'b1;
        end
        #40;
        strobe = 1'b0;
        sdin   = 1'b0;
        #100;
    endtask

    initial begin
        #2000000;
        if (!done_flag) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #1;
        // R1 reset state
        #20;
        chk("R1 en in reset", sdout_en, 0);
        chk("R1 valid in reset", rx_valid, 0);
        do_reset(1'b0);
        chk("R1 en after reset", sdout_en, 0);
        chk("R1 rx_byte after reset", rx_byte, 8'h00);

        // table walk, synchronous mode
        for (int k = 0; k < 7; k++) begin
            int v0;
            law_a    = VEC[k][34];
            tx_mute  = VEC[k][33];
            rx_mute  = VEC[k][32];
            enc_byte = VEC[k][31:24];
            v0 = vcnt;
            do_frame(VEC[k][23:16], 8);
            chk("R2/R5/R7 tx byte", got_tx, VEC[k][15:8]);
            chk("R3/R6/R7 rx byte", rx_byte, VEC[k][7:0]);
            chk("R8 one valid", vcnt - v0, 1);
            chk("R4 en in slot", en_ok, 1);
            chk("R4 en after slot", sdout_en, 0);
        end
        law_a = 0; tx_mute = 0; rx_mute = 0;

        // R9 short slot, synchronous
        begin
            int v0;
            enc_byte = 8'hC8;
            v0 = vcnt;
            do_frame(8'hAA, 5);
            chk("R9 no valid", vcnt - v0, 0);
            chk("R9 rx_byte kept", rx_byte, 8'h00);
            chk("R2 partial tx", got_tx[7:3], 5'b11001);
        end

        // R1 reset inside an open slot
        strobe = 1'b1;
        #100;
        chk("R4 en with strobe high", sdout_en, 1);
        rst_n = 1'b0;
        #20;
        chk("R1 en dropped by reset", sdout_en, 0);

        // asynchronous mode
        do_reset(1'b1);
        begin
            int v0;
            enc_byte = 8'h11; v0 = vcnt;
            do_frame(8'h22, 8);
            chk("R10 first slot quiet", got_tx, 8'h7F);
            chk("R11 nothing yet", vcnt - v0, 0);

            enc_byte = 8'h33; v0 = vcnt;
            do_frame(8'h44, 8);
            chk("R10 delayed tx", got_tx, 8'h11);
            chk("R11 delayed valid", vcnt - v0, 1);
            chk("R11 delayed rx", rx_byte, 8'h22);

            enc_byte = 8'h55; v0 = vcnt;
            do_frame(8'h99, 4);
            chk("R10 partial tx", got_tx[7:4], 4'h3);
            chk("R11 rx at rise", rx_byte, 8'h44);
            chk("R11 one valid", vcnt - v0, 1);

            enc_byte = 8'h66; v0 = vcnt;
            do_frame(8'h77, 8);
            chk("R10 tx after short", got_tx, 8'h55);
            chk("R9 short not delivered", vcnt - v0, 0);
            chk("R9 rx kept", rx_byte, 8'h44);

            enc_byte = 8'h00; v0 = vcnt;
            do_frame(8'h00, 8);
            chk("R10 tx chain", got_tx, 8'h66);
            chk("R11 rx chain", rx_byte, 8'h77);
            chk("R8 single pulse", vcnt - v0, 1);
        end

        done_flag = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule